// File: doc/BRIEF.md
# Priority Scanning Touch Keyboard Encoder

This block turns a row of thirty touch keys into one 5-bit note code. A free-running 5-bit address steps through 32 positions, one per clock. The upper address bit selects one of two 16-way selector banks, and the lower four bits pick a position inside that bank. The keys are visited from the highest note to the lowest. The first touched key met in a sweep sets a hit latch, which loads the current address into the note register and ignores every later key in the same sweep. The highest key held therefore always wins.

When the address wraps from 31 to 0, the hit latch is cleared and its state is copied into a key-down flag. The result is re-evaluated once per sweep. A new key-down produces a single-cycle envelope strobe.

A random pad input also captures whatever address the counter holds at that moment, so it yields an unpredictable note. Through this pad the capture can land on address 31, a reserved code that no key can produce. A flag marks that code.

Top module: `keyscan_encoder`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) note is 0, key_down is 0, env_trig is 0 and skip_hit is 0.
- R2: The sweep address increments by one every clock and wraps from 31 to 0. Address a (0 to 29) reads key touch[29-a]; addresses 30 and 31 read as not touched. A single held key touch[k] is captured as note code 29-k.
- R3: When several keys are held, the note code is that of the highest-index key (the lowest address), because the first hit in a sweep blocks later ones.
- R4: key_down becomes 1 at the wrap edge that ends a sweep in which a capture happened, and 0 at the wrap edge that ends a sweep without one. note keeps its last value while nothing is captured.
- R5: env_trig is high for exactly one cycle, at the same edge where key_down goes from 0 to 1. It never pulses while key_down stays 1.
- R6: rnd_pad high in a cycle with no earlier capture in the current sweep loads the current address into note. It has no effect once a capture has been made in that sweep.
- R7: skip_hit is 1 exactly when note equals 11111 (31). Only the random pad can produce that code.
- R8: key_down changes only at the edge where the address wraps from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| touch | input | KEYS (30) | Key touched lines, active high; bit 0 is the lowest note |
| rnd_pad | input | 1 | Random pad, active high; captures the current address |
| note | output | AW (5) | Captured note code (sweep address of the winning key) |
| key_down | output | 1 | A key or the pad was active during the last sweep |
| env_trig | output | 1 | One-cycle strobe on a new key-down |
| skip_hit | output | 1 | Captured note equals the reserved code 31 |

## Verification
The bench presses every single key and every "key plus all lower keys" pattern. A reversed key order or a wrong bank split shows up as a wrong code, and a hit latch that fails to block later hits would let a lower key overwrite the highest one. The bench pulses the random pad at chosen sweep addresses, including 31, and checks that the pad is ignored after an earlier key hit in the same sweep. It also checks that the reserved code raises skip_hit. Releasing all keys must drop key_down while the note holds its value, and the bench counts envelope strobes across a press-and-hold: a strobe that repeats every sweep, or that is missing, is reported.

// File: rtl/keyscan_encoder.sv
module keyscan_encoder #(
  parameter int KEYS = 30,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KEYS-1:0] touch,
  input  logic            rnd_pad,
  output logic [AW-1:0]   note,
  output logic            key_down,
  output logic            env_trig,
  output logic            skip_hit
);
  localparam int SW   = AW - 1;
  localparam int BANK = 1 << SW;

  logic [AW-1:0]   addr;
  logic            hit;
  logic [BANK-1:0] bank_lo, bank_hi;
  logic            sel, grab, wrap;

  for (genvar p = 0; p < BANK; p++) begin : g_pos
    if (p < KEYS) begin : g_lo_key
      assign bank_lo[p] = touch[KEYS-1-p];
    end else begin : g_lo_nc
      assign bank_lo[p] = 1'b0;
    end
    if (p + BANK < KEYS) begin : g_hi_key
      assign bank_hi[p] = touch[KEYS-1-BANK-p];
    end else begin : g_hi_nc
      assign bank_hi[p] = 1'b0;
    end
  end

  assign sel      = addr[AW-1] ? bank_hi[addr[SW-1:0]] : bank_lo[addr[SW-1:0]];
  assign grab     = (sel | rnd_pad) & ~hit;
  assign wrap     = &addr;
  assign skip_hit = &note;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr     <= '0;
      hit      <= 1'b0;
      note     <= '0;
      key_down <= 1'b0;
      env_trig <= 1'b0;
    end else begin
      addr     <= addr + AW'(1);
      env_trig <= wrap & ~key_down & (hit | grab);
      if (grab) note <= addr;
      if (wrap) begin
        key_down <= hit | grab;
        hit      <= 1'b0;
      end else if (grab) begin
        hit <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/keyscan_encoder_chk.sv
module keyscan_encoder_chk #(
  parameter int KEYS = 30,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [KEYS-1:0] touch,
  input logic            rnd_pad,
  input logic [AW-1:0]   addr,
  input logic [AW-1:0]   note,
  input logic            key_down,
  input logic            env_trig,
  input logic            skip_hit
);
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> addr == $past(addr) + AW'(1));

  p_note_needs_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (note != $past(note)) |-> ($past(rnd_pad) || ($past(touch) != '0)));

  p_trig_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    env_trig |-> (key_down && !$past(key_down)));

  p_skip_from_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(skip_hit) |-> $past(rnd_pad));

  p_kd_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_down != $past(key_down)) |-> ($past(addr) == {AW{1'b1}}));
endmodule

bind keyscan_encoder keyscan_encoder_chk #(.KEYS(KEYS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .touch(touch), .rnd_pad(rnd_pad), .addr(addr),
  .note(note), .key_down(key_down), .env_trig(env_trig), .skip_hit(skip_hit)
);

// File: tb/sim_keyscan_encoder.sv
`timescale 1ns/1ps
module sim_keyscan_encoder;
  localparam int KEYS = 30;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [KEYS-1:0] touch = '0;
  logic            rnd_pad = 1'b0;
  logic [4:0]      note;
  logic            key_down, env_trig, skip_hit;

  int checks = 0;
  int errors = 0;
  int bcnt   = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) bcnt <= 0;
    else        bcnt <= bcnt + 1;
  end

  keyscan_encoder #(.KEYS(KEYS), .AW(5)) u0 (
    .clk(clk), .rst_n(rst_n), .touch(touch), .rnd_pad(rnd_pad),
    .note(note), .key_down(key_down), .env_trig(env_trig), .skip_hit(skip_hit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_addr(input int a);
    @(negedge clk);
    while ((bcnt % 32) != a) @(negedge clk);
  endtask

  task automatic pad_at(input int a);
    wait_addr(a);
    rnd_pad = 1'b1;
    @(negedge clk);
    rnd_pad = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int trig_cnt, bad_cnt;
    idle(3);
    chk(note == 0, "R1 note", note, 0);
    chk(key_down == 0, "R1 key_down", key_down, 0);
    chk(env_trig == 0, "R1 env_trig", env_trig, 0);
    chk(skip_hit == 0, "R1 skip_hit", skip_hit, 0);
    rst_n = 1'b1;
    idle(70);
    chk(key_down == 0, "R4 idle key_down", key_down, 0);
    chk(note == 0, "R4 idle note", note, 0);

    // R2: every single key
    for (int k = 0; k < KEYS; k++) begin
      touch = '0;
      touch[k] = 1'b1;
      idle(70);
      chk(note == 5'(29 - k), "R2 single key code", note, 29 - k);
      chk(key_down == 1, "R4 key_down held", key_down, 1);
      chk(skip_hit == 0, "R7 no skip from key", skip_hit, 0);
    end

    // R3: key plus all lower keys, highest must win
    for (int k = 0; k < KEYS; k++) begin
      touch = '0;
      for (int j = 0; j <= k; j++) touch[j] = 1'b1;
      idle(70);
      chk(note == 5'(29 - k), "R3 highest wins", note, 29 - k);
    end
    touch = '0;
    touch[3] = 1'b1; touch[20] = 1'b1; touch[29] = 1'b1;
    idle(70);
    chk(note == 0, "R3 top key with others", note, 0);

    // R4: release holds note, drops key_down
    touch = '0;
    touch[12] = 1'b1;
    idle(70);
    touch = '0;
    idle(70);
    chk(key_down == 0, "R4 released key_down", key_down, 0);
    chk(note == 17, "R4 note held", note, 17);

    // R5: one strobe per new press, none while held
    trig_cnt = 0; bad_cnt = 0;
    touch[5] = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (env_trig) trig_cnt++;
      if (env_trig && !key_down) bad_cnt++;
    end
    chk(trig_cnt == 1, "R5 strobe count on press", trig_cnt, 1);
    chk(bad_cnt == 0, "R5 strobe with key_down", bad_cnt, 0);
    trig_cnt = 0;
    touch[5] = 1'b0; touch[6] = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (env_trig) trig_cnt++;
    end
    chk(trig_cnt == 0, "R5 no strobe while held", trig_cnt, 0);
    chk(note == 23, "R2 moved key code", note, 23);
    touch = '0;
    idle(70);

    // R6: pad captures current address
    pad_at(7);
    chk(note == 7, "R6 pad capture mid sweep", note, 7);
    idle(70);
    chk(key_down == 0, "R4 pad released key_down", key_down, 0);

    // R6: pad ignored after earlier hit in same sweep
    touch[29] = 1'b1;
    idle(40);
    pad_at(10);
    chk(note == 0, "R6 pad ignored after hit", note, 0);
    touch = '0;
    idle(70);

    // R7: reserved code through the pad
    pad_at(31);
    chk(note == 31, "R7 pad at 31 note", note, 31);
    chk(skip_hit == 1, "R7 skip flag set", skip_hit, 1);
    chk(key_down == 1, "R8 key_down at wrap", key_down, 1);
    idle(70);
    chk(key_down == 0, "R4 after pad key_down", key_down, 0);
    chk(skip_hit == 1, "R7 skip flag held", skip_hit, 1);
    touch[0] = 1'b1;
    idle(70);
    chk(skip_hit == 0, "R7 skip flag cleared", skip_hit, 0);
    chk(note == 29, "R2 lowest key code", note, 29);
    touch = '0;

    // R8: key_down only moves at the wrap
    idle(40);
    wait_addr(3);
    touch[10] = 1'b1;
    idle(10);
    chk(key_down == 0, "R8 no early key_down", key_down, 0);
    wait_addr(0);
    chk(key_down == 1, "R8 key_down after wrap", key_down, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule